// File: doc/BRIEF.md
# Short Backward-Loop Replay Controller

This block sits next to a six-stage in-order pipeline and keeps a short history of the instructions most recently accepted by decode. When decode sees a branch that is predicted taken, and the branch jumps backwards by a small distance, the loop body is still inside that history. The controller then stops instruction fetch and feeds the loop back into the pipeline from its own slots, one instruction per cycle, for as long as the loop keeps going.

Two states make up the controller. `WATCH` is the normal state: fetch runs and decoded instructions are shifted into the history window. The transition *capture hit* goes from `WATCH` to `REPLAY` when a qualifying branch is decoded. In `REPLAY`, fetch is held, decode input is ignored and the captured body is replayed. The transition *clear* goes from `REPLAY` back to `WATCH` when an interrupt arrives, an external flush arrives, a misprediction is reported, or the loop branch resolves not-taken. Each clear also empties the history window.

Displacements count instructions and are relative to the branch. A displacement of 0 is a branch to itself, and a displacement of −(DEPTH−1) reaches the oldest slot. The loop length is therefore 1 − displacement, which allows up to DEPTH instructions.

Top module: `loop_replay_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `fetch_hold`, `replay_valid`, `flush_out` and `resume_fallthru` are 0 when the resolve inputs are idle.
- R2: In WATCH, a decoded instruction with `dec_is_branch`=1, `dec_pred_taken`=1 and a signed `dec_disp` d in the range −(DEPTH−1) ≤ d ≤ 0 moves the block to REPLAY on the next cycle, provided at least −d instructions were captured before it since the last clear. From that cycle on, `fetch_hold` and `replay_valid` are 1.
- R3: No entry takes place if d > 0, d < −(DEPTH−1), the branch is not predicted taken, or the instruction is not a branch.
- R4: On the first replay cycle `replay_instr` is the instruction decoded −d positions before the branch. Each following cycle gives the next younger instruction. After the branch itself, the sequence wraps back to the target.
- R5: In REPLAY, `dec_valid` and the other decode inputs have no effect: the replayed body stays the same.
- R6: In REPLAY, when `res_valid`=1, `res_taken`=0 and `res_mispredict`=0 with no interrupt or external flush, `flush_out` and `resume_fallthru` are 1 in that same cycle and the block is in WATCH on the next cycle. `resume_fallthru` is never 1 in WATCH.
- R7: `res_valid`=1 together with `res_mispredict`=1 drives `flush_out`=1 in the same cycle in either state. It returns the block to WATCH, blocks an entry in that cycle and clears the history.
- R8: `irq` or `ext_flush` returns the block to WATCH on the next cycle, blocks an entry in that cycle, clears the history and suppresses `resume_fallthru`.
- R9: In REPLAY, a resolve with `res_taken`=1 and `res_mispredict`=0 keeps the block in REPLAY without a flush.
- R10: The count of captured instructions restarts at zero after every clear. An entry therefore needs −d fresh decodes before the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_instr | input | IW | Decoded instruction word |
| dec_is_branch | input | 1 | Instruction is a conditional branch |
| dec_pred_taken | input | 1 | Branch predicted taken at decode |
| dec_disp | input | DW | Signed branch displacement in instructions |
| res_valid | input | 1 | Memory-stage branch resolution present |
| res_taken | input | 1 | Resolved direction is taken |
| res_mispredict | input | 1 | Resolution disagrees with the prediction |
| irq | input | 1 | Interrupt taken |
| ext_flush | input | 1 | External pipeline flush |
| fetch_hold | output | 1 | Suppress instruction fetch |
| replay_valid | output | 1 | `replay_instr` is to be injected |
| replay_instr | output | IW | Replayed instruction |
| flush_out | output | 1 | Flush instructions younger than the resolving branch |
| resume_fallthru | output | 1 | Resume fetch at the loop fall-through address |

## Verification
The hardest cases are those where a capture hit in WATCH falls in the same cycle as a clear source, or where the not-taken exit in REPLAY falls in the same cycle as an interrupt. The bench provokes both on purpose. It drives the qualifying branch in the same cycle as `ext_flush` or as a mispredict resolution, and it drives a not-taken resolve in the same cycle as `irq`. A behavioural model built on a queue is compared with every output on every clock. The model expects the clear to win: no entry happens, the history is emptied, and `resume_fallthru` stays 0 while `flush_out` still follows the resolve.

// File: rtl/lr_pkg.sv
package lr_pkg;
    typedef enum logic [0:0] {
        LR_WATCH  = 1'b0,
        LR_REPLAY = 1'b1
    } lr_state_e;
endpackage

// File: rtl/lr_window.sv
// History of the most recent decoded instructions; slot 0 is the youngest.
module lr_window #(
    parameter int IW    = 32,
    parameter int DEPTH = 6,
    parameter int PW    = 3,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          shift_en,
    input  logic [IW-1:0] din,
    input  logic [PW-1:0] rd_idx,
    output logic [IW-1:0] rd_data,
    output logic [CW-1:0] cnt
);
    logic [IW-1:0] slot_q [DEPTH];
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (shift_en && !clear) begin
            slot_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) slot_q[i] <= slot_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (shift_en && (cnt_q < CW'(DEPTH)))
            cnt_q <= cnt_q + CW'(1);
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == PW'(i)) rd_data = slot_q[i];
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/lr_detect.sv
// Decides whether a decoded instruction closes a loop held in the window.
module lr_detect #(
    parameter int DW    = 8,
    parameter int DEPTH = 6,
    parameter int PW    = 3,
    parameter int CW    = 3
) (
    input  logic          dec_valid,
    input  logic          dec_is_branch,
    input  logic          dec_pred_taken,
    input  logic [DW-1:0] dec_disp,
    input  logic [CW-1:0] hist_cnt,
    output logic          hit,
    output logic [PW-1:0] start
);
    localparam logic [DW-1:0] MAX_MAG = DW'(DEPTH - 1);

    logic [DW-1:0] mag;
    logic          in_range;

    always_comb begin
        mag      = -dec_disp;
        in_range = (dec_disp == '0) ||
                   (dec_disp[DW-1] && !mag[DW-1] && (mag <= MAX_MAG));
        start    = in_range ? mag[PW-1:0] : '0;
        hit      = dec_valid && dec_is_branch && dec_pred_taken && in_range &&
                   (hist_cnt >= CW'(start));
    end
endmodule

// File: rtl/lr_seq.sv
// Replay pointer: counts down from the target age to the branch, then wraps.
module lr_seq #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] start_in,
    input  logic          advance,
    output logic [PW-1:0] ptr
);
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] start_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            start_q <= '0;
        end else if (load) begin
            ptr_q   <= start_in;
            start_q <= start_in;
        end else if (advance) begin
            ptr_q   <= (ptr_q == '0) ? start_q : ptr_q - PW'(1);
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/loop_replay_ctrl.sv
module loop_replay_ctrl
    import lr_pkg::*;
#(
    parameter int IW    = 32,
    parameter int DW    = 8,
    parameter int DEPTH = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [IW-1:0] dec_instr,
    input  logic          dec_is_branch,
    input  logic          dec_pred_taken,
    input  logic [DW-1:0] dec_disp,
    input  logic          res_valid,
    input  logic          res_taken,
    input  logic          res_mispredict,
    input  logic          irq,
    input  logic          ext_flush,
    output logic          fetch_hold,
    output logic          replay_valid,
    output logic [IW-1:0] replay_instr,
    output logic          flush_out,
    output logic          resume_fallthru
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    lr_state_e     state_q, state_d;
    logic          kill, clear, hit, shift_en, load;
    logic [PW-1:0] start, ptr;
    logic [CW-1:0] hist_cnt;
    logic [IW-1:0] rd_data;

    assign kill      = irq || ext_flush;
    assign flush_out = res_valid &&
                       (res_mispredict || ((state_q == LR_REPLAY) && !res_taken));
    assign clear     = kill || flush_out;
    assign shift_en  = (state_q == LR_WATCH) && dec_valid && !clear;
    assign load      = (state_q == LR_WATCH) && hit && !clear;

    lr_window #(.IW(IW), .DEPTH(DEPTH), .PW(PW), .CW(CW)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (shift_en),
        .din      (dec_instr),
        .rd_idx   (ptr),
        .rd_data  (rd_data),
        .cnt      (hist_cnt)
    );

    lr_detect #(.DW(DW), .DEPTH(DEPTH), .PW(PW), .CW(CW)) u_detect (
        .dec_valid      (dec_valid),
        .dec_is_branch  (dec_is_branch),
        .dec_pred_taken (dec_pred_taken),
        .dec_disp       (dec_disp),
        .hist_cnt       (hist_cnt),
        .hit            (hit),
        .start          (start)
    );

    lr_seq #(.PW(PW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .start_in (start),
        .advance  (state_q == LR_REPLAY),
        .ptr      (ptr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LR_WATCH;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LR_WATCH:  if (load)  state_d = LR_REPLAY;
            LR_REPLAY: if (clear) state_d = LR_WATCH;
            default:              state_d = LR_WATCH;
        endcase
    end

    // outputs
    always_comb begin
        fetch_hold      = 1'b0;
        replay_valid    = 1'b0;
        replay_instr    = '0;
        resume_fallthru = 1'b0;
        unique case (state_q)
            LR_WATCH: ;
            LR_REPLAY: begin
                fetch_hold      = 1'b1;
                replay_valid    = 1'b1;
                replay_instr    = rd_data;
                resume_fallthru = res_valid && !res_taken && !res_mispredict && !kill;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lr_checker.sv
module lr_checker #(
    parameter int DW    = 8,
    parameter int DEPTH = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec_valid,
    input logic          dec_is_branch,
    input logic          dec_pred_taken,
    input logic [DW-1:0] dec_disp,
    input logic          res_valid,
    input logic          res_taken,
    input logic          res_mispredict,
    input logic          irq,
    input logic          ext_flush,
    input logic          fetch_hold,
    input logic          flush_out,
    input logic          resume_fallthru
);
    AST_NO_BAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_hold && (!dec_valid || !dec_is_branch || !dec_pred_taken ||
          ($signed(dec_disp) > 0) || ($signed(dec_disp) < -(DEPTH - 1))))
        |=> !fetch_hold); // R3

    AST_NOTTAKEN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hold && res_valid && !res_taken) |=> !fetch_hold); // R6

    AST_RESUME_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        resume_fallthru |-> (fetch_hold && flush_out && !irq && !ext_flush)); // R6

    AST_MISPRED_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mispredict) |-> flush_out); // R7

    AST_MISPRED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mispredict) |=> !fetch_hold); // R7

    AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || ext_flush) |=> !fetch_hold); // R8

    AST_LOOP_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hold && !irq && !ext_flush &&
         !(res_valid && (res_mispredict || !res_taken))) |=> fetch_hold); // R9
endmodule

bind loop_replay_ctrl lr_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .dec_valid       (dec_valid),
    .dec_is_branch   (dec_is_branch),
    .dec_pred_taken  (dec_pred_taken),
    .dec_disp        (dec_disp),
    .res_valid       (res_valid),
    .res_taken       (res_taken),
    .res_mispredict  (res_mispredict),
    .irq             (irq),
    .ext_flush       (ext_flush),
    .fetch_hold      (fetch_hold),
    .flush_out       (flush_out),
    .resume_fallthru (resume_fallthru)
);

// File: tb/loop_replay_ctrl_tb.sv
`timescale 1ns/100ps
module loop_replay_ctrl_tb;
    localparam int IW = 32, DW = 8, DEPTH = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dec_valid = 0, dec_is_branch = 0, dec_pred_taken = 0;
    logic [IW-1:0] dec_instr = '0;
    logic [DW-1:0] dec_disp = '0;
    logic res_valid = 0, res_taken = 0, res_mispredict = 0, irq = 0, ext_flush = 0;
    logic fetch_hold, replay_valid, flush_out, resume_fallthru;
    logic [IW-1:0] replay_instr;

    always #2.5 clk = ~clk;

    loop_replay_ctrl #(.IW(IW), .DW(DW), .DEPTH(DEPTH)) u_dut (.*);

    int n_tests = 0, n_fail = 0;
    string req_tag = "R1";
    bit finished = 0;

    // behavioural model
    logic [IW-1:0] hist[$];
    bit m_loop = 0;
    int m_start = 0, m_ptr = 0;
    int serial = 0;

    task automatic chk(string what, logic [IW-1:0] act, logic [IW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req_tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit kill, e_flush, e_res;
        kill    = irq || ext_flush;
        e_flush = res_valid && (res_mispredict || (m_loop && !res_taken));
        e_res   = m_loop && res_valid && !res_taken && !res_mispredict && !kill;
        chk("fetch_hold", IW'(fetch_hold), IW'(m_loop));
        chk("replay_valid", IW'(replay_valid), IW'(m_loop));
        chk("flush_out", IW'(flush_out), IW'(e_flush));
        chk("resume_fallthru", IW'(resume_fallthru), IW'(e_res));
        if (m_loop) chk("replay_instr", replay_instr, hist[m_ptr]);
    endtask

    task automatic model_update();
        bit kill, flush, enter;
        int d;
        kill  = irq || ext_flush;
        flush = res_valid && (res_mispredict || (m_loop && !res_taken));
        d     = int'($signed(dec_disp));
        if (kill || flush) begin
            m_loop = 0;
            hist.delete();
        end else if (m_loop) begin
            m_ptr = (m_ptr == 0) ? m_start : m_ptr - 1;
        end else if (dec_valid) begin
            enter = dec_is_branch && dec_pred_taken && d <= 0 && d >= -(DEPTH-1) &&
                    hist.size() >= -d;
            hist.push_front(dec_instr);
            if (hist.size() > DEPTH) void'(hist.pop_back());
            if (enter) begin
                m_loop = 1; m_start = -d; m_ptr = -d;
            end
        end
    endtask

    task automatic tick();
        #1;
        compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        dec_valid = 0; dec_is_branch = 0; dec_pred_taken = 0; dec_disp = '0;
        res_valid = 0; res_taken = 0; res_mispredict = 0; irq = 0; ext_flush = 0;
    endtask

    task automatic plain(int n);
        for (int i = 0; i < n; i++) begin
            serial++;
            dec_valid = 1; dec_instr = 32'hA000_0000 + serial;
            tick();
        end
    endtask

    task automatic branch(int d, bit pt);
        serial++;
        dec_valid = 1; dec_instr = 32'hB000_0000 + serial;
        dec_is_branch = 1; dec_pred_taken = pt; dec_disp = DW'(d);
    endtask

    task automatic garbage_cycles(int n);   // decode noise during replay
        for (int i = 0; i < n; i++) begin
            dec_valid = 1; dec_instr = 32'hDEAD_0000 + i;
            dec_is_branch = 1; dec_pred_taken = 1; dec_disp = DW'(-1);
            tick();
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        req_tag = "R1";
        repeat (3) begin #1; compare(); @(negedge clk); end
        rst_n = 1;
        tick();

        // R2 / R4 / R5: three-instruction loop, decode noise while replaying
        plain(3);
        req_tag = "R2"; branch(-2, 1); tick();
        req_tag = "R4"; tick(); tick();
        req_tag = "R5"; garbage_cycles(7);
        req_tag = "R6"; res_valid = 1; res_taken = 0; tick();
        tick();

        // R10 / R3: history restarted, out-of-range and non-qualifying
        plain(1);
        req_tag = "R10"; branch(-2, 1); tick();
        plain(6);
        req_tag = "R3"; branch(1, 1); tick();
        branch(-6, 1); tick();
        branch(-1, 0); tick();
        dec_valid = 1; dec_instr = 32'hC000_0001; dec_pred_taken = 1; dec_disp = DW'(-1); tick();
        req_tag = "R6"; res_valid = 1; res_taken = 0; tick();

        // R2 / R9 / R7: six-instruction loop, taken resolves, then mispredict
        req_tag = "R2"; branch(-5, 1); tick();
        req_tag = "R4"; repeat (8) tick();
        req_tag = "R9"; res_valid = 1; res_taken = 1; tick();
        tick();
        res_valid = 1; res_taken = 1; tick();
        req_tag = "R7"; res_valid = 1; res_taken = 1; res_mispredict = 1; tick();
        tick();

        // R2 / R8: single-instruction loop right after a clear, then interrupt
        req_tag = "R2"; branch(0, 1); tick();
        req_tag = "R4"; repeat (3) tick();
        req_tag = "R8"; irq = 1; tick();
        tick();

        // R8 / R7: entry colliding with a clear source
        plain(2);
        req_tag = "R8"; branch(-1, 1); ext_flush = 1; tick();
        plain(2);
        req_tag = "R7"; branch(-1, 1); res_valid = 1; res_mispredict = 1; tick();
        plain(2);
        req_tag = "R2"; branch(-1, 1); tick();
        req_tag = "R4"; repeat (4) tick();

        // R8: not-taken exit colliding with interrupt
        req_tag = "R8"; res_valid = 1; res_taken = 0; irq = 1; tick();
        tick();

        // R6: not-taken resolve outside replay gives no flush and no resume
        req_tag = "R6"; res_valid = 1; res_taken = 0; tick();
        plain(2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule